// File: doc/BRIEF.md
# Hashed Page-Table Group Index Generator

This block turns a translation request into the two page-table group locations where a matching entry may live. A request carries an effective address, a virtual segment identifier, a segment-size select (small 256 MB segments or large 1 TB segments) and a page-size shift. The first stage merges the segment identifier with the in-segment part of the effective address to form the virtual address, and it clamps the page shift into its legal span. The second stage folds the virtual address into a 39-bit hash, derives the alternate hash, and masks both with the table mask. The block reports each result as a group index and as a group byte offset.

Each of the two stages is a slot with two named states, SLOT_EMPTY and SLOT_FULL. The transitions are LOAD (SLOT_EMPTY to SLOT_FULL when an item is taken), REFILL (SLOT_FULL stays SLOT_FULL when one item leaves and another enters in the same cycle), HOLD (SLOT_FULL stays SLOT_FULL when the item cannot leave) and DRAIN (SLOT_FULL to SLOT_EMPTY when the item leaves and nothing enters). Both ends of the block use a valid/ready handshake. The lookup engine that sits downstream may stall the output as long as it needs, and items then back up into the first stage and finally stop the input.

Top module: `ghash_index_gen`

## Requirements
- R1: With `seg_large`=0, the virtual address is the segment identifier shifted left by 28, OR'd with `ea[27:0]`. The hash is (VA >> 28) XOR (VA[27:0] >> shift), kept to its low 39 bits.
- R2: With `seg_large`=1, the virtual address is the segment identifier shifted left by 40, OR'd with `ea[39:0]`, kept to 64 bits, so only identifier bits [23:0] survive. With S = VA >> 40, the hash is S XOR (S << 25) XOR (VA[39:0] >> shift).
- R3: Every hash is truncated to bits [38:0]. Bits that the fold by 25 pushes above bit 38 are dropped.
- R4: The secondary hash is the bitwise complement of the primary hash over 39 bits. On any valid output, `out_pri_idx & out_sec_idx` is zero.
- R5: Each group index is its hash ANDed with `tbl_mask`. The mask is sampled when the item enters the second stage. Each byte offset is the matching index times 128, that is, the index with seven zero bits appended.
- R6: A `page_shift` below 12 is used as 12, and one above 24 is used as 24. In both cases `out_clamped` is 1 for that item. A shift in 12..24 is used unchanged, with `out_clamped`=0.
- R7: With `out_ready` held high, an item accepted at clock edge k appears on the outputs right after edge k+1, which is a latency of two edges. Items leave in the order they entered, and none is lost or duplicated.
- R8: While `out_valid`=1 and `out_ready`=0, the outputs hold their values and stay valid. With both stages full and the output stalled, `in_ready` is 0. When `out_valid` is 0, `in_ready` is 1.
- R9: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| ea | input | 64 | Effective address |
| vsid | input | 36 | Virtual segment identifier |
| seg_large | input | 1 | 0: 256 MB segment, 1: 1 TB segment |
| page_shift | input | 5 | Page-size shift (legal 12..24) |
| tbl_mask | input | 39 | Hash table group mask |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes result |
| out_pri_idx | output | 39 | Primary group index |
| out_sec_idx | output | 39 | Secondary group index |
| out_pri_off | output | 46 | Primary group byte offset |
| out_sec_off | output | 46 | Secondary group byte offset |
| out_clamped | output | 1 | Page shift was out of range and clamped |

## Verification
The two functions that can coincide are the second stage handing a result downstream and the first stage accepting a new request, which together make the REFILL transition. A DRAIN or HOLD can also happen in the second stage while the first stage is loading. Random toggling of `in_valid` and `out_ready` drives the stages through all of these overlaps. A scoreboard then checks that every item comes out once, in order, with the hash and clamp flag the formulas predict. Directed stalls fill both stages and confirm that `in_ready` drops and the held outputs do not change.

// File: rtl/ghash_pkg.sv
package ghash_pkg;
    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_FULL  = 1'b1
    } slot_state_e;
endpackage

// File: rtl/ghash_va_stage.sv
module ghash_va_stage
    import ghash_pkg::*;
#(
    parameter int VA_W      = 64,
    parameter int VSID_W    = 36,
    parameter int SHIFT_W   = 5,
    parameter int SMALL_SEG = 28,
    parameter int LARGE_SEG = 40,
    parameter int MIN_SHIFT = 12,
    parameter int MAX_SHIFT = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [VA_W-1:0]    ea,
    input  logic [VSID_W-1:0]  vsid,
    input  logic               seg_large,
    input  logic [SHIFT_W-1:0] page_shift,
    output logic               s1_valid,
    input  logic               s1_ready,
    output logic [VA_W-1:0]    s1_va,
    output logic [SHIFT_W-1:0] s1_shift,
    output logic               s1_clamped,
    output logic               s1_large
);
    localparam logic [VA_W-1:0]    SMALL_MASK = (VA_W'(1) << SMALL_SEG) - VA_W'(1);
    localparam logic [VA_W-1:0]    LARGE_MASK = (VA_W'(1) << LARGE_SEG) - VA_W'(1);
    localparam logic [SHIFT_W-1:0] LO_SHIFT   = SHIFT_W'(MIN_SHIFT);
    localparam logic [SHIFT_W-1:0] HI_SHIFT   = SHIFT_W'(MAX_SHIFT);

    slot_state_e        st_q, st_d;
    logic               take, give;
    logic [VA_W-1:0]    va_d;
    logic [SHIFT_W-1:0] shift_d;
    logic               clamp_d;

    assign s1_valid = (st_q == SLOT_FULL);
    assign in_ready = (st_q == SLOT_EMPTY) || s1_ready;
    assign take     = in_valid && in_ready;
    assign give     = s1_valid && s1_ready;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= SLOT_EMPTY;
        else        st_q <= st_d;
    end

    // Transitions: LOAD, REFILL, HOLD, DRAIN
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SLOT_EMPTY: if (take) st_d = SLOT_FULL;
            SLOT_FULL:  if (give && !take) st_d = SLOT_EMPTY;
            default:    st_d = SLOT_EMPTY;
        endcase
    end

    // Virtual address build and shift clamp
    always_comb begin
        if (seg_large)
            va_d = (VA_W'(vsid) << LARGE_SEG) | (ea & LARGE_MASK);
        else
            va_d = (VA_W'(vsid) << SMALL_SEG) | (ea & SMALL_MASK);
        clamp_d = 1'b0;
        shift_d = page_shift;
        if (page_shift < LO_SHIFT) begin
            shift_d = LO_SHIFT;
            clamp_d = 1'b1;
        end else if (page_shift > HI_SHIFT) begin
            shift_d = HI_SHIFT;
            clamp_d = 1'b1;
        end
    end

    // Slot contents
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_va      <= '0;
            s1_shift   <= LO_SHIFT;
            s1_clamped <= 1'b0;
            s1_large   <= 1'b0;
        end else if (take) begin
            s1_va      <= va_d;
            s1_shift   <= shift_d;
            s1_clamped <= clamp_d;
            s1_large   <= seg_large;
        end
    end

    AST_SHIFT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |-> (s1_shift >= LO_SHIFT && s1_shift <= HI_SHIFT)); // R6
    AST_S1_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && !s1_ready) |=> (s1_valid && $stable(s1_va) && $stable(s1_shift))); // R8
endmodule

// File: rtl/ghash_mask_stage.sv
module ghash_mask_stage
    import ghash_pkg::*;
#(
    parameter int VA_W      = 64,
    parameter int SHIFT_W   = 5,
    parameter int HASH_W    = 39,
    parameter int SMALL_SEG = 28,
    parameter int LARGE_SEG = 40,
    parameter int FOLD      = 25
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               s1_valid,
    output logic               s1_ready,
    input  logic [VA_W-1:0]    s1_va,
    input  logic [SHIFT_W-1:0] s1_shift,
    input  logic               s1_clamped,
    input  logic               s1_large,
    input  logic [HASH_W-1:0]  tbl_mask,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [HASH_W-1:0]  pri_idx,
    output logic [HASH_W-1:0]  sec_idx,
    output logic               clamped
);
    localparam logic [VA_W-1:0] SMALL_MASK = (VA_W'(1) << SMALL_SEG) - VA_W'(1);
    localparam logic [VA_W-1:0] LARGE_MASK = (VA_W'(1) << LARGE_SEG) - VA_W'(1);

    slot_state_e       st_q, st_d;
    logic              take, give;
    logic [HASH_W-1:0] seg_part, off_part, hash_pri, hash_sec;

    assign out_valid = (st_q == SLOT_FULL);
    assign s1_ready  = (st_q == SLOT_EMPTY) || out_ready;
    assign take      = s1_valid && s1_ready;
    assign give      = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= SLOT_EMPTY;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SLOT_EMPTY: if (take) st_d = SLOT_FULL;
            SLOT_FULL:  if (give && !take) st_d = SLOT_EMPTY;
            default:    st_d = SLOT_EMPTY;
        endcase
    end

    // Segment-size dependent hash fold, truncated to HASH_W bits
    always_comb begin
        if (s1_large) begin
            seg_part = HASH_W'(s1_va >> LARGE_SEG);
            seg_part = seg_part ^ (seg_part << FOLD);
            off_part = HASH_W'((s1_va & LARGE_MASK) >> s1_shift);
        end else begin
            seg_part = HASH_W'(s1_va >> SMALL_SEG);
            off_part = HASH_W'((s1_va & SMALL_MASK) >> s1_shift);
        end
        hash_pri = seg_part ^ off_part;
        hash_sec = ~hash_pri;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pri_idx <= '0;
            sec_idx <= '0;
            clamped <= 1'b0;
        end else if (take) begin
            pri_idx <= hash_pri & tbl_mask;
            sec_idx <= hash_sec & tbl_mask;
            clamped <= s1_clamped;
        end
    end

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(pri_idx) && $stable(sec_idx) && $stable(clamped))); // R8
    AST_PAIR_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((pri_idx & sec_idx) == '0)); // R4
endmodule

// File: rtl/ghash_index_gen.sv
module ghash_index_gen #(
    parameter int VA_W      = 64,
    parameter int VSID_W    = 36,
    parameter int SHIFT_W   = 5,
    parameter int HASH_W    = 39,
    parameter int SMALL_SEG = 28,
    parameter int LARGE_SEG = 40,
    parameter int FOLD      = 25,
    parameter int MIN_SHIFT = 12,
    parameter int MAX_SHIFT = 24,
    parameter int GROUP_LOG2 = 7,
    localparam int OFF_W    = HASH_W + GROUP_LOG2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [VA_W-1:0]    ea,
    input  logic [VSID_W-1:0]  vsid,
    input  logic               seg_large,
    input  logic [SHIFT_W-1:0] page_shift,
    input  logic [HASH_W-1:0]  tbl_mask,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [HASH_W-1:0]  out_pri_idx,
    output logic [HASH_W-1:0]  out_sec_idx,
    output logic [OFF_W-1:0]   out_pri_off,
    output logic [OFF_W-1:0]   out_sec_off,
    output logic               out_clamped
);
    logic               s1_valid, s1_ready, s1_clamped, s1_large;
    logic [VA_W-1:0]    s1_va;
    logic [SHIFT_W-1:0] s1_shift;

    ghash_va_stage #(
        .VA_W(VA_W), .VSID_W(VSID_W), .SHIFT_W(SHIFT_W),
        .SMALL_SEG(SMALL_SEG), .LARGE_SEG(LARGE_SEG),
        .MIN_SHIFT(MIN_SHIFT), .MAX_SHIFT(MAX_SHIFT)
    ) u_va (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready),
        .ea(ea), .vsid(vsid), .seg_large(seg_large), .page_shift(page_shift),
        .s1_valid(s1_valid), .s1_ready(s1_ready),
        .s1_va(s1_va), .s1_shift(s1_shift),
        .s1_clamped(s1_clamped), .s1_large(s1_large)
    );

    ghash_mask_stage #(
        .VA_W(VA_W), .SHIFT_W(SHIFT_W), .HASH_W(HASH_W),
        .SMALL_SEG(SMALL_SEG), .LARGE_SEG(LARGE_SEG), .FOLD(FOLD)
    ) u_mask (
        .clk(clk), .rst_n(rst_n),
        .s1_valid(s1_valid), .s1_ready(s1_ready),
        .s1_va(s1_va), .s1_shift(s1_shift),
        .s1_clamped(s1_clamped), .s1_large(s1_large),
        .tbl_mask(tbl_mask),
        .out_valid(out_valid), .out_ready(out_ready),
        .pri_idx(out_pri_idx), .sec_idx(out_sec_idx),
        .clamped(out_clamped)
    );

    assign out_pri_off = {out_pri_idx, {GROUP_LOG2{1'b0}}};
    assign out_sec_off = {out_sec_idx, {GROUP_LOG2{1'b0}}};

    AST_READY_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready); // R8
    AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && s1_valid) |-> !in_ready); // R8
endmodule

// File: tb/ghash_index_gen_bench.sv
module ghash_index_gen_bench;
    typedef struct packed {
        logic [38:0] pri;
        logic [38:0] sec;
        logic        clamp;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [63:0] ea = '0;
    logic [35:0] vsid = '0;
    logic        seg_large = 1'b0;
    logic [4:0]  page_shift = 5'd12;
    logic [38:0] tbl_mask = '1;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [38:0] out_pri_idx, out_sec_idx;
    logic [45:0] out_pri_off, out_sec_off;
    logic        out_clamped;

    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    always #5 clk = ~clk;

    ghash_index_gen u_ghash_index_gen (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready),
        .ea(ea), .vsid(vsid), .seg_large(seg_large), .page_shift(page_shift),
        .tbl_mask(tbl_mask),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_pri_idx(out_pri_idx), .out_sec_idx(out_sec_idx),
        .out_pri_off(out_pri_off), .out_sec_off(out_sec_off),
        .out_clamped(out_clamped)
    );

    function automatic exp_t model(input logic [63:0] a, input logic [35:0] sid,
                                   input logic big, input logic [4:0] sh_in,
                                   input logic [38:0] msk);
        exp_t        e;
        logic [63:0] va, h, s;
        int          sh;
        e.clamp = (sh_in < 5'd12) || (sh_in > 5'd24);              // R6
        sh = (sh_in < 5'd12) ? 12 : ((sh_in > 5'd24) ? 24 : int'(sh_in));
        if (!big) begin                                            // R1
            va = ({28'd0, sid} << 28) | {36'd0, a[27:0]};
            h  = (va >> 28) ^ ({36'd0, va[27:0]} >> sh);
        end else begin                                             // R2
            va = ({28'd0, sid} << 40) | {24'd0, a[39:0]};
            s  = va >> 40;
            h  = s ^ (s << 25) ^ ({24'd0, va[39:0]} >> sh);
        end
        e.pri = h[38:0] & msk;                                     // R3, R5
        e.sec = (~h[38:0]) & msk;                                  // R4
        return e;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Scoreboard and hold monitor, sampled 1 time unit after each falling edge
    initial begin
        logic        prev_stall;
        logic [38:0] prev_pri;
        prev_stall = 1'b0;
        prev_pri   = '0;
        forever begin
            @(negedge clk);
            #1;
            if (rst_n) begin
                if (prev_stall) begin
                    check(out_valid == 1'b1, "R8", "valid dropped during stall", 64'(out_valid), 64'd1);
                    check(out_pri_idx == prev_pri, "R8", "output changed during stall", 64'(out_pri_idx), 64'(prev_pri));
                end
                if (in_valid && in_ready)
                    sb.push_back(model(ea, vsid, seg_large, page_shift, tbl_mask));
                if (out_valid && out_ready) begin
                    if (sb.size() == 0) begin
                        check(1'b0, "R7", "unexpected output", 64'(out_pri_idx), 64'd0);
                    end else begin
                        exp_t e;
                        e = sb.pop_front();
                        check(out_pri_idx == e.pri, "R1/R2 primary (R5 R7)", "pri_idx", 64'(out_pri_idx), 64'(e.pri));
                        check(out_sec_idx == e.sec, "R4", "sec_idx", 64'(out_sec_idx), 64'(e.sec));
                        check(out_clamped == e.clamp, "R6", "clamped", 64'(out_clamped), 64'(e.clamp));
                        check(out_pri_off == {e.pri, 7'd0}, "R5", "pri_off", 64'(out_pri_off), 64'({e.pri, 7'd0}));
                        check(out_sec_off == {e.sec, 7'd0}, "R5", "sec_off", 64'(out_sec_off), 64'({e.sec, 7'd0}));
                    end
                end
                prev_stall = out_valid && !out_ready;
                prev_pri   = out_pri_idx;
            end
        end
    end

    task automatic put(input logic [63:0] a, input logic [35:0] sid, input logic big,
                       input logic [4:0] sh);
        @(negedge clk);
        in_valid   = 1'b1;
        ea         = a;
        vsid       = sid;
        seg_large  = big;
        page_shift = sh;
    endtask

    task automatic drain();
        @(negedge clk);
        in_valid  = 1'b0;
        out_ready = 1'b1;
        repeat (6) @(negedge clk);
        check(sb.size() == 0, "R7", "items left in flight", 64'(sb.size()), 64'd0);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0C0D));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R9", "out_valid after reset", 64'(out_valid), 64'd0);
        check(in_ready == 1'b1, "R9", "in_ready after reset", 64'(in_ready), 64'd1);

        // R7 latency: accept at edge k, visible after edge k+1
        put(64'h0000_0000_0123_4567, 36'h9_ABCD_EF01, 1'b0, 5'd12);
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid == 1'b0, "R7", "valid one edge after accept", 64'(out_valid), 64'd0);
        @(negedge clk);
        check(out_valid == 1'b1, "R7", "valid two edges after accept", 64'(out_valid), 64'd1);
        drain();

        // Directed corners: clamp, truncation, masks
        tbl_mask = '1;
        put('1, '1, 1'b1, 5'd0);                         // R3 R6 low clamp, large segment
        put('1, '1, 1'b0, 5'd31);                        // R6 high clamp
        put(64'h0000_00AB_CDEF_0123, 36'h0_00FF_FFFF, 1'b1, 5'd24);  // R2 edge shift
        put(64'h0F00_0000_0FFF_F000, 36'h0_0000_0001, 1'b0, 5'd11);  // R6 just below
        put(64'h0000_0000_0000_0000, 36'h0_0000_0000, 1'b0, 5'd25);  // R6 just above
        put(64'h1234_5678_9ABC_DEF0, 36'hF_FFFF_FFFF, 1'b1, 5'd16);  // R2 upper sid bits dropped
        drain();
        tbl_mask = 39'h0_0000_07FF;                      // R5 narrow mask
        put(64'h0000_0000_0FFF_FFFF, 36'h5_5555_5555, 1'b0, 5'd12);
        put(64'h0000_00FF_FFFF_FFFF, 36'h0_0AAA_AAAA, 1'b1, 5'd20);
        drain();
        tbl_mask = '0;                                   // R5 zero mask
        put(64'h0000_0000_0ABC_DEF0, 36'h1_2345_6789, 1'b0, 5'd13);
        drain();

        // R8 backpressure: both stages fill, in_ready drops
        tbl_mask  = '1;
        out_ready = 1'b0;
        put(64'h0000_0000_0111_1000, 36'h0_0000_0011, 1'b0, 5'd12);
        put(64'h0000_0000_0222_2000, 36'h0_0000_0022, 1'b1, 5'd12);
        put(64'h0000_0000_0333_3000, 36'h0_0000_0033, 1'b0, 5'd12);
        #2;
        check(in_ready == 1'b0, "R8", "in_ready with both stages full", 64'(in_ready), 64'd0);
        repeat (3) @(negedge clk);
        check(in_ready == 1'b0, "R8", "in_ready still low", 64'(in_ready), 64'd0);
        drain();

        // Constrained random phases, new mask per phase
        for (int ph = 0; ph < 8; ph++) begin
            tbl_mask = {7'($urandom), 32'($urandom)};
            if (ph == 0) tbl_mask = '1;
            for (int i = 0; i < 300; i++) begin
                @(negedge clk);
                in_valid   = ($urandom % 4) != 0;
                out_ready  = ($urandom % 3) != 0;
                ea         = {32'($urandom), 32'($urandom)};
                vsid       = {4'($urandom), 32'($urandom)};
                seg_large  = 1'($urandom);
                page_shift = ($urandom % 5 == 0) ? 5'($urandom) : 5'(12 + ($urandom % 13));
            end
            drain();
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule